// File: doc/BRIEF.md
# Register Transfer Datapath with Shared Bus and Memory Port

This block is a small register-transfer datapath. Four source registers share one bus. A decoder turns a binary source select into a one-hot enable, and the bus is the AND-OR of those enables with the register outputs. It behaves like a set of enabled buffers on a common line, but it has no high-impedance state. Every destination has its own load enable. A register can load the bus, an external data word, or the memory data register. The address register loads from the bus. A 16-word memory is read into the data register and written from the bus, at the address held in the address register.

All transfers are gated by one control condition input. When that condition is high, every enabled transfer happens on the same clock edge. Each transfer uses the values that the registers held before that edge. A sequencer outside this block drives the select, load and memory controls.

Top module: `regbus_datapath`

## Requirements
- R1: Synchronous reset clears all four registers, the address register and the data register to 0 on the next rising edge, whatever the other inputs are. Memory contents are not cleared.
- R2: `bus_q` equals the register chosen by `src_sel`: 0 gives register 0, 1 gives register 1, 2 gives register 2 and 3 gives register 3. The bus is combinational.
- R3: `src_enable` is one-hot, with bit `src_sel` set and every other bit clear.
- R4: While `ctrl_p` is 0 no register, address register, data register or memory word changes, whatever the load, read and write inputs are.
- R5: With `ctrl_p`=1 and `ld_src`=00, every register whose `reg_ld` bit is set loads `bus_q` on the next edge. Registers whose bits are clear, including the bus source, keep their values.
- R6: `ld_src`=01 loads `din` and `ld_src`=10 loads the data register into the enabled registers. `ld_src`=11 loads nothing.
- R7: All transfers enabled in one cycle happen on the same edge and use the values from before that edge. A register that reloads in the same cycle as a memory write does not change the word that is written.
- R8: With `ctrl_p`=1 and `ar_ld`=1, the address register loads the low 4 bits of `bus_q`.
- R9: With `ctrl_p`=1 and `mem_rd`=1, the data register loads the memory word at the address register on the next edge.
- R10: With `ctrl_p`=1 and `mem_wr`=1, the memory word at the address register takes `bus_q`.
- R11: A read and a write to the same word in one cycle return the word as it was before the write.
- R12: A memory access in the same cycle as an address register load uses the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_p | input | 1 | Control condition that gates every transfer |
| src_sel | input | 2 | Bus source register select |
| reg_ld | input | 4 | Per-register load enable |
| ld_src | input | 2 | Register load source: 00 bus, 01 din, 10 data register, 11 none |
| din | input | 4 | External data word |
| ar_ld | input | 1 | Load the address register from the bus |
| mem_rd | input | 1 | Memory read into the data register |
| mem_wr | input | 1 | Memory write from the bus |
| src_enable | output | 4 | One-hot bus source enable |
| bus_q | output | 4 | Shared bus value |
| reg_q | output | 16 | Registers packed, register k at bits 4k+3:4k |
| ar_q | output | 4 | Address register |
| dr_q | output | 4 | Data register |

## Verification
The properties assume that `src_sel` and `ld_src` are never X or Z after reset. The stability property also assumes that nothing outside the port list changes state. The stimulus drives every control to a defined value at every falling edge, starting during reset. The bench never reads a memory word before it has written that word, so the uninitialised contents never reach `dr_q` or a register.

// File: rtl/regbus_pkg.sv
`timescale 1ns/1ps
package regbus_pkg;
  typedef enum logic [1:0] {
    LD_BUS  = 2'b00,
    LD_DIN  = 2'b01,
    LD_DR   = 2'b10,
    LD_NONE = 2'b11
  } ld_src_e;
endpackage

// File: rtl/regbus_srcdec.sv
`timescale 1ns/1ps
// Binary select to one-hot source enable.
module regbus_srcdec #(
  parameter int NSRC = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic [SELW-1:0] sel,
  output logic [NSRC-1:0] en
);
  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    assign en[i] = (sel == SELW'(i));
  end
endmodule

// File: rtl/regbus_busmux.sv
`timescale 1ns/1ps
// One-hot AND-OR bus: bit b is the OR of bit b of every enabled source.
module regbus_busmux #(
  parameter int NSRC = 4,
  parameter int DW   = 4
) (
  input  logic [NSRC-1:0]    en,
  input  logic [NSRC*DW-1:0] srcs,
  output logic [DW-1:0]      bus
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic [NSRC-1:0] column;
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign column[s] = srcs[s*DW + b];
    end
    assign bus[b] = |(column & en);
  end
endmodule

// File: rtl/regbus_regfile.sv
`timescale 1ns/1ps
// Destination registers with individual load enables and a shared load source.
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int DW   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_p,
  input  logic [NSRC-1:0]    ld,
  input  logic [1:0]         ld_src,
  input  logic [DW-1:0]      bus,
  input  logic [DW-1:0]      din,
  input  logic [DW-1:0]      dr,
  output logic [NSRC*DW-1:0] q
);
  ld_src_e src;
  assign src = ld_src_e'(ld_src);

  for (genvar k = 0; k < NSRC; k++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r <= '0;
      end else if (ctrl_p && ld[k]) begin
        case (src)
          LD_BUS:  r <= bus;
          LD_DIN:  r <= din;
          LD_DR:   r <= dr;
          default: r <= r;
        endcase
      end
    end
    assign q[k*DW +: DW] = r;
  end
endmodule

// File: rtl/regbus_memport.sv
`timescale 1ns/1ps
// Address register, data register and a word memory laid out for block RAM.
module regbus_memport #(
  parameter int DW = 4,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_p,
  input  logic          ar_ld,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] bus,
  output logic [AW-1:0] ar,
  output logic [DW-1:0] dr
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst)                 ar <= '0;
    else if (ctrl_p && ar_ld) ar <= bus[AW-1:0];
  end

  // Write port: no reset, so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    if (!rst && ctrl_p && wr) mem[ar] <= bus;
  end

  // Synchronous read into the data register; the read sees the old word.
  always_ff @(posedge clk) begin
    if (rst)              dr <= '0;
    else if (ctrl_p && rd) dr <= mem[ar];
  end
endmodule

// File: rtl/regbus_datapath.sv
`timescale 1ns/1ps
// Top level: registers, one-hot bus and memory port.
module regbus_datapath #(
  parameter int NSRC = 4,
  parameter int DW   = 4,
  parameter int AW   = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_p,
  input  logic [SELW-1:0]    src_sel,
  input  logic [NSRC-1:0]    reg_ld,
  input  logic [1:0]         ld_src,
  input  logic [DW-1:0]      din,
  input  logic               ar_ld,
  input  logic               mem_rd,
  input  logic               mem_wr,
  output logic [NSRC-1:0]    src_enable,
  output logic [DW-1:0]      bus_q,
  output logic [NSRC*DW-1:0] reg_q,
  output logic [AW-1:0]      ar_q,
  output logic [DW-1:0]      dr_q
);
  regbus_srcdec #(.NSRC(NSRC)) u_dec (
    .sel (src_sel),
    .en  (src_enable)
  );

  regbus_busmux #(.NSRC(NSRC), .DW(DW)) u_bus (
    .en   (src_enable),
    .srcs (reg_q),
    .bus  (bus_q)
  );

  regbus_regfile #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ctrl_p (ctrl_p),
    .ld     (reg_ld),
    .ld_src (ld_src),
    .bus    (bus_q),
    .din    (din),
    .dr     (dr_q),
    .q      (reg_q)
  );

  regbus_memport #(.DW(DW), .AW(AW)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .ctrl_p (ctrl_p),
    .ar_ld  (ar_ld),
    .rd     (mem_rd),
    .wr     (mem_wr),
    .bus    (bus_q),
    .ar     (ar_q),
    .dr     (dr_q)
  );
endmodule

// File: rtl/regbus_checker.sv
`timescale 1ns/1ps
module regbus_checker #(
  parameter int NSRC = 4,
  parameter int DW   = 4,
  parameter int AW   = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               ctrl_p,
  input logic [SELW-1:0]    src_sel,
  input logic [NSRC-1:0]    reg_ld,
  input logic [1:0]         ld_src,
  input logic               ar_ld,
  input logic [NSRC-1:0]    src_enable,
  input logic [DW-1:0]      bus_q,
  input logic [NSRC*DW-1:0] reg_q,
  input logic [AW-1:0]      ar_q,
  input logic [DW-1:0]      dr_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (reg_q == '0) && (ar_q == '0) && (dr_q == '0));

  p_bus_source_r2: assert property (@(posedge clk) disable iff (rst)
    bus_q == reg_q[src_sel*DW +: DW]);

  p_single_enable_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(src_enable) == 1);

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_p |=> $stable(reg_q) && $stable(ar_q) && $stable(dr_q));

  for (genvar k = 0; k < NSRC; k++) begin : g_ld
    p_load_from_bus_r5: assert property (@(posedge clk) disable iff (rst)
      (ctrl_p && reg_ld[k] && ld_src == 2'b00) |=> reg_q[k*DW +: DW] == $past(bus_q));
  end

  p_no_load_code_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_p && ld_src == 2'b11) |=> $stable(reg_q));

  p_addr_load_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_p && ar_ld) |=> ar_q == $past(bus_q[AW-1:0]));
endmodule

bind regbus_datapath regbus_checker #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_p     (ctrl_p),
  .src_sel    (src_sel),
  .reg_ld     (reg_ld),
  .ld_src     (ld_src),
  .ar_ld      (ar_ld),
  .src_enable (src_enable),
  .bus_q      (bus_q),
  .reg_q      (reg_q),
  .ar_q       (ar_q),
  .dr_q       (dr_q)
);

// File: tb/regbus_datapath_bench.sv
`timescale 1ns/1ps
module regbus_datapath_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_p = 1'b0;
  logic [1:0]  src_sel = '0;
  logic [3:0]  reg_ld = '0;
  logic [1:0]  ld_src = '0;
  logic [3:0]  din = '0;
  logic        ar_ld = 1'b0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic [3:0]  src_enable;
  logic [3:0]  bus_q;
  logic [15:0] reg_q;
  logic [3:0]  ar_q;
  logic [3:0]  dr_q;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  regbus_datapath u_regbus_datapath (
    .clk(clk), .rst(rst), .ctrl_p(ctrl_p), .src_sel(src_sel), .reg_ld(reg_ld),
    .ld_src(ld_src), .din(din), .ar_ld(ar_ld), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .src_enable(src_enable), .bus_q(bus_q), .reg_q(reg_q), .ar_q(ar_q), .dr_q(dr_q)
  );

  typedef struct packed {
    logic        p;
    logic [1:0]  sel;
    logic [3:0]  ld;
    logic [1:0]  src;
    logic        arl;
    logic        rd;
    logic        wr;
    logic [3:0]  d;
    logic [15:0] e_regs;
    logic [3:0]  e_ar;
    logic [3:0]  e_dr;
  } step_t;

  localparam int NSTEP = 20;
  // Expected register word is {R3,R2,R1,R0}; rows run in order after reset.
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 2'd0, 4'b0001, 2'd1, 1'b0, 1'b0, 1'b0, 4'h5, 16'h0005, 4'h0, 4'h0},
    '{1'b1, 2'd0, 4'b0010, 2'd1, 1'b0, 1'b0, 1'b0, 4'hA, 16'h00A5, 4'h0, 4'h0},
    '{1'b1, 2'd0, 4'b0100, 2'd1, 1'b0, 1'b0, 1'b0, 4'h3, 16'h03A5, 4'h0, 4'h0},
    '{1'b1, 2'd0, 4'b1000, 2'd1, 1'b0, 1'b0, 1'b0, 4'hC, 16'hC3A5, 4'h0, 4'h0},
    '{1'b1, 2'd0, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'h0, 16'hC3A5, 4'h0, 4'h0},
    '{1'b0, 2'd3, 4'b1111, 2'd1, 1'b1, 1'b1, 1'b1, 4'hF, 16'hC3A5, 4'h0, 4'h0},
    '{1'b1, 2'd0, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 4'h0, 16'hC3A5, 4'h0, 4'h5},
    '{1'b1, 2'd1, 4'b0000, 2'd0, 1'b1, 1'b0, 1'b0, 4'h0, 16'hC3A5, 4'hA, 4'h5},
    '{1'b1, 2'd3, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'h0, 16'hC3A5, 4'hA, 4'h5},
    '{1'b1, 2'd2, 4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'h0, 16'hC3A5, 4'h3, 4'hC},
    '{1'b1, 2'd0, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'h0, 16'hC3A5, 4'h3, 4'hC},
    '{1'b1, 2'd1, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b1, 4'h0, 16'hC3A5, 4'h3, 4'h5},
    '{1'b1, 2'd0, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 4'h0, 16'hC3A5, 4'h3, 4'hA},
    '{1'b1, 2'd0, 4'b0001, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0, 16'hC3AA, 4'h3, 4'hA},
    '{1'b1, 2'd3, 4'b0110, 2'd0, 1'b0, 1'b0, 1'b0, 4'h0, 16'hCCCA, 4'h3, 4'hA},
    '{1'b1, 2'd1, 4'b0010, 2'd1, 1'b1, 1'b0, 1'b1, 4'h7, 16'hCC7A, 4'hC, 4'hA},
    '{1'b1, 2'd0, 4'b0100, 2'd1, 1'b0, 1'b0, 1'b0, 4'h3, 16'hC37A, 4'hC, 4'hA},
    '{1'b1, 2'd2, 4'b0000, 2'd0, 1'b1, 1'b0, 1'b0, 4'h0, 16'hC37A, 4'h3, 4'hA},
    '{1'b1, 2'd0, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 4'h0, 16'hC37A, 4'h3, 4'hC},
    '{1'b1, 2'd0, 4'b1111, 2'd3, 1'b0, 1'b0, 1'b0, 4'hF, 16'hC37A, 4'h3, 4'hC}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_p = 1'b0; reg_ld = '0; ld_src = '0; din = '0;
    ar_ld = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0; src_sel = '0;
  endtask

  initial begin
    logic [15:0] prev_regs;
    prev_regs = '0;
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: the reset state
    check("R1 regs after reset", 32'(reg_q), 32'h0);
    check("R1 ar after reset",   32'(ar_q),  32'h0);
    check("R1 dr after reset",   32'(dr_q),  32'h0);
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      ctrl_p = TBL[i].p; src_sel = TBL[i].sel; reg_ld = TBL[i].ld;
      ld_src = TBL[i].src; ar_ld = TBL[i].arl; mem_rd = TBL[i].rd;
      mem_wr = TBL[i].wr; din = TBL[i].d;
      #1;
      check("R2 bus value",  32'(bus_q), 32'(prev_regs[TBL[i].sel*4 +: 4]));
      check("R3 one-hot enable", 32'(src_enable), 32'(4'b0001 << TBL[i].sel));
      @(posedge clk);
      #1;
      check("R4 R5 R6 R7 registers", 32'(reg_q), 32'(TBL[i].e_regs));
      check("R8 R12 address register", 32'(ar_q), 32'(TBL[i].e_ar));
      check("R9 R10 R11 data register", 32'(dr_q), 32'(TBL[i].e_dr));
      prev_regs = TBL[i].e_regs;
    end

    // R1: reset has priority over active transfers
    @(negedge clk);
    rst = 1'b1; ctrl_p = 1'b1; reg_ld = 4'b1111; ld_src = 2'd1; din = 4'hF;
    ar_ld = 1'b1; mem_rd = 1'b1; src_sel = 2'd3;
    @(posedge clk);
    #1;
    check("R1 regs cleared under load", 32'(reg_q), 32'h0);
    check("R1 ar cleared under load",   32'(ar_q),  32'h0);
    check("R1 dr cleared under read",   32'(dr_q),  32'h0);
    @(negedge clk);
    idle();
    rst = 1'b0;
    src_sel = 2'd3;
    #1;
    check("R2 bus after reset", 32'(bus_q), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule